// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block caches virtual-to-physical page translations for a processor memory pipeline. Every entry carries a virtual page number, one of four page sizes, a partition identifier, a context identifier and a flag marking real (untranslated-space) mappings. Each cycle a lookup key is compared against all entries in parallel, and one clock edge later the block reports whether a translation was found, which entry holds it, and the physical address built from the stored page and the request's offset bits.

New translations arrive on an insert port. The block picks a victim with a used-bit scheme: an entry is marked used when it is written or hit, and when every entry has become used, the used marks of all unlocked entries are swept clear except the one just touched. Locked entries keep their mark, so the victim search skips them. An insert also removes any stored translation whose address range overlaps the new one under the same partition, context and real flag, so a key never matches two entries.

A maintenance port removes translations by page, by context, by partition or all at once, and a readback port returns the packed tag word and the stored translation word of any entry. Maintenance, insert and the used-bit update on a lookup hit share one update slot per cycle, taken in that order of precedence.

Top module: `xlate_cache`

## Requirements
- R1: After reset no entry is valid: `lk_hit` is 0, and a lookup of the all-zero key (address 0, partition 0, context 0, real 0) misses.
- R2: A lookup presented with `lk_valid` high is answered on the next cycle: `lk_hit` high, `lk_idx` naming the matching entry, and `lk_pa` equal to the physical page field of the stored translation word (bits PA_W-1 and down) above the page offset, combined with the request address bits below it. Without a match `lk_hit` is 0.
- R3: Page size is bits 1:0 of the translation word: 0 = 8 KB, 1 = 64 KB, 2 = 4 MB, 3 = 256 MB. A lookup matches an entry only when the address bits above that entry's page offset agree and the partition, context and real flag are all equal.
- R4: An insert is written to the lowest-numbered entry that is invalid or not used; when every entry is valid and used, the highest-numbered entry is overwritten. The translation word bit 6 marks an entry locked.
- R5: An inserted entry becomes valid and used, and every other entry with the same partition, context and real flag whose range overlaps the new one (compared above the larger of the two page offsets) becomes invalid and not used.
- R6: A lookup hit marks that entry used. When an insert or a hit leaves every entry used, all unlocked entries except the one just written or hit lose their used mark; locked entries keep it. A used entry is always valid.
- R7: Maintenance operation 0 (page) invalidates the entry that a lookup with the same address, partition, context and real flag would hit.
- R8: Maintenance operation 1 (context) invalidates every entry whose partition and context match, locked entries included, regardless of real flag.
- R9: Maintenance operation 2 (partition) invalidates every unlocked entry of the given partition and leaves locked ones valid.
- R10: Maintenance operation 3 (all) invalidates every entry and clears every used mark, so the following inserts fill entries from 0 upward.
- R11: One cycle after `rd_idx` is presented, `rd_tte` holds that entry's translation word and `rd_tag` holds context in bits 12:0, the virtual page in bits VA_W-1:13, the inverted size code in bits 57:56, the real flag in bit 60 and the partition in bits 63:61, other bits zero.
- R12: When maintenance and insert are requested in the same cycle, only the maintenance takes effect; a lookup in the same cycle is answered from the state before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| lk_part | input | 3 | Lookup partition |
| lk_ctx | input | 13 | Lookup context |
| lk_real | input | 1 | Lookup real-space flag |
| lk_hit | output | 1 | Registered hit result |
| lk_idx | output | log2(ENTRIES) | Registered index of the hit entry |
| lk_pa | output | PA_W | Registered physical address |
| ins_valid | input | 1 | Insert request |
| ins_va | input | VA_W | Virtual address of the new translation |
| ins_part | input | 3 | Partition of the new translation |
| ins_ctx | input | 13 | Context of the new translation |
| ins_real | input | 1 | Real-space flag of the new translation |
| ins_tte | input | 64 | Translation word (size 1:0, lock 6, physical page PA_W-1:13) |
| cmd_valid | input | 1 | Maintenance request |
| cmd_op | input | 2 | 0 page, 1 context, 2 partition, 3 all |
| cmd_va | input | VA_W | Address for page scope |
| cmd_part | input | 3 | Partition for page, context and partition scopes |
| cmd_ctx | input | 13 | Context for page and context scopes |
| cmd_real | input | 1 | Real-space flag for page scope |
| rd_idx | input | log2(ENTRIES) | Readback entry index |
| rd_tag | output | 64 | Registered packed tag word |
| rd_tte | output | 64 | Registered translation word |

## Verification
The bench builds the block with four entries, a 56-bit virtual address and a 40-bit physical address. Four entries make the full-table condition arrive after a handful of inserts, so the bulk used-mark sweep, the skipping of locked entries and the fall-back to the last entry when all four are locked are each reached in a short directed sequence. All four page sizes are stored at once, so offset masking and physical address assembly are checked for each size, and one 64 KB insert over an 8 KB page exercises conflict removal at the larger offset.

// File: rtl/xc_pkg.sv
package xc_pkg;

    localparam int XC_CTX_W    = 13;
    localparam int XC_PART_W   = 3;
    localparam int XC_TTE_W    = 64;
    localparam int XC_PAGE_LSB = 13;
    localparam int XC_LOCK_BIT = 6;

    typedef enum logic [1:0] {
        XC_OP_PAGE = 2'd0,
        XC_OP_CTX  = 2'd1,
        XC_OP_PART = 2'd2,
        XC_OP_ALL  = 2'd3
    } xc_op_e;

    // Offset mask for a page size code: 8 KB, 64 KB, 4 MB, 256 MB.
    function automatic logic [63:0] xc_off_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return 64'h0000_0000_0000_1FFF;
            2'd1:    return 64'h0000_0000_0000_FFFF;
            2'd2:    return 64'h0000_0000_003F_FFFF;
            default: return 64'h0000_0000_0FFF_FFFF;
        endcase
    endfunction

    // Two addresses fall in the same page of the given size.
    function automatic logic xc_same_page(input logic [63:0] a,
                                          input logic [63:0] b,
                                          input logic [1:0]  sz);
        return ((a ^ b) & ~xc_off_mask(sz)) == 64'd0;
    endfunction

    function automatic logic [1:0] xc_max_sz(input logic [1:0] a, input logic [1:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/xc_entry_cmp.sv
module xc_entry_cmp
    import xc_pkg::*;
#(
    parameter int VA_W = 56
) (
    input  logic                 e_valid,
    input  logic [VA_W-14:0]     e_vpn,
    input  logic [1:0]           e_sz,
    input  logic [XC_PART_W-1:0] e_part,
    input  logic [XC_CTX_W-1:0]  e_ctx,
    input  logic                 e_rl,
    input  logic                 e_lock,
    input  logic [VA_W-1:0]      lk_va,
    input  logic [XC_PART_W-1:0] lk_part,
    input  logic [XC_CTX_W-1:0]  lk_ctx,
    input  logic                 lk_rl,
    input  logic [VA_W-1:0]      cmd_va,
    input  logic [XC_PART_W-1:0] cmd_part,
    input  logic [XC_CTX_W-1:0]  cmd_ctx,
    input  logic                 cmd_rl,
    input  logic [VA_W-1:0]      ins_va,
    input  logic [1:0]           ins_sz,
    input  logic [XC_PART_W-1:0] ins_part,
    input  logic [XC_CTX_W-1:0]  ins_ctx,
    input  logic                 ins_rl,
    output logic                 lk_hit,
    output logic                 pg_hit,
    output logic                 ctx_hit,
    output logic                 part_hit,
    output logic                 ins_conf
);

    logic [63:0] e_va64;
    logic [63:0] lk_va64;
    logic [63:0] cmd_va64;
    logic [63:0] ins_va64;

    always_comb begin
        e_va64                         = '0;
        e_va64[VA_W-1:XC_PAGE_LSB]     = e_vpn;
        lk_va64                        = 64'(lk_va);
        cmd_va64                       = 64'(cmd_va);
        ins_va64                       = 64'(ins_va);

        lk_hit   = e_valid && (e_part == lk_part) && (e_ctx == lk_ctx) && (e_rl == lk_rl)
                   && xc_same_page(e_va64, lk_va64, e_sz);
        pg_hit   = e_valid && (e_part == cmd_part) && (e_ctx == cmd_ctx) && (e_rl == cmd_rl)
                   && xc_same_page(e_va64, cmd_va64, e_sz);
        ctx_hit  = e_valid && (e_part == cmd_part) && (e_ctx == cmd_ctx);
        part_hit = e_valid && (e_part == cmd_part) && !e_lock;
        ins_conf = e_valid && (e_part == ins_part) && (e_ctx == ins_ctx) && (e_rl == ins_rl)
                   && xc_same_page(e_va64, ins_va64, xc_max_sz(e_sz, ins_sz));
    end

endmodule

// File: rtl/xc_pick.sv
module xc_pick #(
    parameter int N     = 64,
    parameter int IDX_W = 6
) (
    input  logic [N-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             found
);

    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
    import xc_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int VA_W    = 56,
    parameter int PA_W    = 40,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int VPN_W  = VA_W - XC_PAGE_LSB
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lk_valid,
    input  logic [VA_W-1:0]      lk_va,
    input  logic [XC_PART_W-1:0] lk_part,
    input  logic [XC_CTX_W-1:0]  lk_ctx,
    input  logic                 lk_real,
    output logic                 lk_hit,
    output logic [IDX_W-1:0]     lk_idx,
    output logic [PA_W-1:0]      lk_pa,
    input  logic                 ins_valid,
    input  logic [VA_W-1:0]      ins_va,
    input  logic [XC_PART_W-1:0] ins_part,
    input  logic [XC_CTX_W-1:0]  ins_ctx,
    input  logic                 ins_real,
    input  logic [XC_TTE_W-1:0]  ins_tte,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic [VA_W-1:0]      cmd_va,
    input  logic [XC_PART_W-1:0] cmd_part,
    input  logic [XC_CTX_W-1:0]  cmd_ctx,
    input  logic                 cmd_real,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [63:0]          rd_tag,
    output logic [XC_TTE_W-1:0]  rd_tte
);

    localparam logic [IDX_W:0]   ENT_LIMIT = (IDX_W + 1)'(ENTRIES);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic [VPN_W-1:0]     vpn;
        logic [XC_PART_W-1:0] part;
        logic [XC_CTX_W-1:0]  ctx;
        logic                 rl;
        logic [XC_TTE_W-1:0]  tte;
    } ent_t;

    typedef struct packed {
        logic [ENTRIES-1:0]  valid;
        logic [ENTRIES-1:0]  used;
        ent_t [ENTRIES-1:0]  ent;
        logic                hit;
        logic [IDX_W-1:0]    idx;
        logic [PA_W-1:0]     pa;
        logic [63:0]         rtag;
        logic [XC_TTE_W-1:0] rtte;
    } state_t;

    state_t st_q, st_d;

    logic [ENTRIES-1:0] lk_hit_vec;
    logic [ENTRIES-1:0] pg_hit_vec;
    logic [ENTRIES-1:0] ctx_hit_vec;
    logic [ENTRIES-1:0] part_hit_vec;
    logic [ENTRIES-1:0] conf_vec;
    logic [ENTRIES-1:0] lock_vec;
    logic [ENTRIES-1:0] free_vec;

    // Per-entry comparators, all evaluated in parallel.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        assign lock_vec[g] = st_q.ent[g].tte[XC_LOCK_BIT];
        xc_entry_cmp #(.VA_W(VA_W)) u_cmp (
            .e_valid  (st_q.valid[g]),
            .e_vpn    (st_q.ent[g].vpn),
            .e_sz     (st_q.ent[g].tte[1:0]),
            .e_part   (st_q.ent[g].part),
            .e_ctx    (st_q.ent[g].ctx),
            .e_rl     (st_q.ent[g].rl),
            .e_lock   (st_q.ent[g].tte[XC_LOCK_BIT]),
            .lk_va    (lk_va),
            .lk_part  (lk_part),
            .lk_ctx   (lk_ctx),
            .lk_rl    (lk_real),
            .cmd_va   (cmd_va),
            .cmd_part (cmd_part),
            .cmd_ctx  (cmd_ctx),
            .cmd_rl   (cmd_real),
            .ins_va   (ins_va),
            .ins_sz   (ins_tte[1:0]),
            .ins_part (ins_part),
            .ins_ctx  (ins_ctx),
            .ins_rl   (ins_real),
            .lk_hit   (lk_hit_vec[g]),
            .pg_hit   (pg_hit_vec[g]),
            .ctx_hit  (ctx_hit_vec[g]),
            .part_hit (part_hit_vec[g]),
            .ins_conf (conf_vec[g])
        );
    end

    assign free_vec = ~st_q.valid | ~st_q.used;

    logic [IDX_W-1:0] free_idx, victim_idx, hit_idx;
    logic             free_found, hit_found;

    xc_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .vec   (free_vec),
        .idx   (free_idx),
        .found (free_found)
    );

    xc_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_hitenc (
        .vec   (lk_hit_vec),
        .idx   (hit_idx),
        .found (hit_found)
    );

    assign victim_idx = free_found ? free_idx : LAST_IDX;

    xc_op_e             op;
    logic [ENTRIES-1:0] clr;
    logic [ENTRIES-1:0] lock_next;
    logic [63:0]        pmask;
    logic [63:0]        tag_w;
    ent_t               new_ent;
    ent_t               rd_ent;
    ent_t               hit_ent;

    always_comb begin
        st_d      = st_q;
        op        = xc_op_e'(cmd_op);
        clr       = '0;
        lock_next = lock_vec;

        new_ent.vpn  = ins_va[VA_W-1:XC_PAGE_LSB];
        new_ent.part = ins_part;
        new_ent.ctx  = ins_ctx;
        new_ent.rl   = ins_real;
        new_ent.tte  = ins_tte;

        if (cmd_valid) begin
            case (op)
                XC_OP_PAGE: clr = pg_hit_vec;
                XC_OP_CTX:  clr = ctx_hit_vec;
                XC_OP_PART: clr = part_hit_vec;
                default:    clr = '1;
            endcase
            st_d.valid = st_q.valid & ~clr;
            st_d.used  = st_q.used & ~clr;
        end else if (ins_valid) begin
            clr                    = conf_vec;
            st_d.valid             = st_q.valid & ~clr;
            st_d.used              = st_q.used & ~clr;
            st_d.ent[victim_idx]   = new_ent;
            st_d.valid[victim_idx] = 1'b1;
            st_d.used[victim_idx]  = 1'b1;
            lock_next[victim_idx]  = ins_tte[XC_LOCK_BIT];
            if (&st_d.used) begin
                st_d.used             = st_d.used & lock_next;
                st_d.used[victim_idx] = 1'b1;
            end
        end else if (lk_valid && hit_found) begin
            st_d.used[hit_idx] = 1'b1;
            if (&st_d.used) begin
                st_d.used          = st_d.used & lock_vec;
                st_d.used[hit_idx] = 1'b1;
            end
        end

        // Lookup result, answered from the pre-update state.
        hit_ent  = st_q.ent[hit_idx];
        pmask    = xc_off_mask(hit_ent.tte[1:0]);
        st_d.hit = lk_valid && hit_found;
        st_d.idx = st_d.hit ? hit_idx : '0;
        st_d.pa  = st_d.hit ? ((hit_ent.tte[PA_W-1:0] & ~pmask[PA_W-1:0])
                              | (lk_va[PA_W-1:0] & pmask[PA_W-1:0]))
                            : '0;

        // Readback of one entry's tag and translation words.
        rd_ent = st_q.ent[rd_idx];
        tag_w  = '0;
        tag_w[XC_CTX_W-1:0]          = rd_ent.ctx;
        tag_w[VA_W-1:XC_PAGE_LSB]    = rd_ent.vpn;
        tag_w[57:56]                 = ~rd_ent.tte[1:0];
        tag_w[60]                    = rd_ent.rl;
        tag_w[63:61]                 = rd_ent.part;
        if ({1'b0, rd_idx} < ENT_LIMIT) begin
            st_d.rtag = tag_w;
            st_d.rtte = rd_ent.tte;
        end else begin
            st_d.rtag = '0;
            st_d.rtte = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lk_hit = st_q.hit;
    assign lk_idx = st_q.idx;
    assign lk_pa  = st_q.pa;
    assign rd_tag = st_q.rtag;
    assign rd_tte = st_q.rtte;

    // ---------------- assertions ----------------

    assert_hit_reported_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && (lk_hit_vec != '0)) |=> lk_hit);

    assert_no_request_no_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !lk_hit);

    assert_insert_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !cmd_valid) |=> (st_q.valid[$past(victim_idx)] && st_q.used[$past(victim_idx)]));

    assert_single_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit_vec));

    assert_used_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.used & ~st_q.valid) == '0);

    assert_page_gone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == XC_OP_PAGE) |=> ((st_q.valid & $past(pg_hit_vec)) == '0));

    assert_ctx_gone_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == XC_OP_CTX) |=> ((st_q.valid & $past(ctx_hit_vec)) == '0));

    assert_part_unlocked_gone_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == XC_OP_PART) |=> ((st_q.valid & $past(part_hit_vec)) == '0));

    assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == XC_OP_ALL) |=> (st_q.valid == '0 && st_q.used == '0));

    assert_maint_blocks_insert_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && ins_valid) |=> ((st_q.valid & ~$past(st_q.valid)) == '0));

endmodule

// File: tb/xlate_cache_test.sv
`timescale 1ns/1ps
module xlate_cache_test;

    localparam int N    = 4;
    localparam int VA_W = 56;
    localparam int PA_W = 40;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n;
    logic             lk_valid;
    logic [VA_W-1:0]  lk_va;
    logic [2:0]       lk_part;
    logic [12:0]      lk_ctx;
    logic             lk_real;
    logic             lk_hit;
    logic [1:0]       lk_idx;
    logic [PA_W-1:0]  lk_pa;
    logic             ins_valid;
    logic [VA_W-1:0]  ins_va;
    logic [2:0]       ins_part;
    logic [12:0]      ins_ctx;
    logic             ins_real;
    logic [63:0]      ins_tte;
    logic             cmd_valid;
    logic [1:0]       cmd_op;
    logic [VA_W-1:0]  cmd_va;
    logic [2:0]       cmd_part;
    logic [12:0]      cmd_ctx;
    logic             cmd_real;
    logic [1:0]       rd_idx;
    logic [63:0]      rd_tag;
    logic [63:0]      rd_tte;

    xlate_cache #(.ENTRIES(N), .VA_W(VA_W), .PA_W(PA_W)) uut (.*);

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_tte(input logic [63:0] pa, input logic [1:0] sz, input logic lk);
        return (pa & ~64'h1FFF) | (64'(lk) << 6) | 64'(sz);
    endfunction

    task automatic do_lookup(input string req, input logic [VA_W-1:0] va, input logic [2:0] p,
                             input logic [12:0] c, input logic r, input logic eh,
                             input logic [1:0] ei, input logic [PA_W-1:0] ep);
        @(negedge clk);
        lk_valid = 1'b1; lk_va = va; lk_part = p; lk_ctx = c; lk_real = r;
        @(negedge clk);
        lk_valid = 1'b0;
        chk({req, " hit"}, 64'(lk_hit), 64'(eh));
        if (eh) begin
            chk({req, " idx"}, 64'(lk_idx), 64'(ei));
            chk({req, " pa"}, 64'(lk_pa), 64'(ep));
        end
    endtask

    task automatic do_insert(input logic [VA_W-1:0] va, input logic [2:0] p, input logic [12:0] c,
                             input logic r, input logic [63:0] tte);
        @(negedge clk);
        ins_valid = 1'b1; ins_va = va; ins_part = p; ins_ctx = c; ins_real = r; ins_tte = tte;
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    task automatic do_cmd(input logic [1:0] op, input logic [VA_W-1:0] va, input logic [2:0] p,
                          input logic [12:0] c, input logic r);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_va = va; cmd_part = p; cmd_ctx = c; cmd_real = r;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_read(input string req, input logic [1:0] idx,
                           input logic [63:0] etag, input logic [63:0] ette);
        @(negedge clk);
        rd_idx = idx;
        @(negedge clk);
        chk({req, " tag"}, rd_tag, etag);
        chk({req, " tte"}, rd_tte, ette);
    endtask

    typedef struct packed {
        logic [55:0] va;
        logic [2:0]  part;
        logic [12:0] ctx;
        logic        rl;
        logic        hit;
        logic [1:0]  idx;
        logic [39:0] pa;
    } vec_t;

    // Lookups against four entries of sizes 8K, 64K, 4M, 256M (R2, R3).
    localparam vec_t VEC [0:8] = '{
        '{56'h0_1234_6ABC, 3'd1, 13'd5, 1'b0, 1'b1, 2'd0, 40'h00_ABCD_EABC},
        '{56'h0_1234_8ABC, 3'd1, 13'd5, 1'b0, 1'b0, 2'd0, 40'h0},
        '{56'h0_0051_FFF8, 3'd1, 13'd5, 1'b0, 1'b1, 2'd1, 40'h00_7777_FFF8},
        '{56'h0_0051_2345, 3'd1, 13'd6, 1'b0, 1'b0, 2'd0, 40'h0},
        '{56'h0_087F_FFF0, 3'd2, 13'd7, 1'b0, 1'b1, 2'd2, 40'h01_007F_FFF0},
        '{56'h0_0840_0010, 3'd3, 13'd7, 1'b0, 1'b0, 2'd0, 40'h0},
        '{56'h0_3ABC_DEF0, 3'd1, 13'd0, 1'b1, 1'b1, 2'd3, 40'h05_1ABC_DEF0},
        '{56'h0_3ABC_DEF0, 3'd1, 13'd0, 1'b0, 1'b0, 2'd0, 40'h0},
        '{56'h0_4000_0000, 3'd1, 13'd0, 1'b1, 1'b0, 2'd0, 40'h0}
    };

    initial begin
        rst_n = 1'b0; lk_valid = 1'b0; ins_valid = 1'b0; cmd_valid = 1'b0;
        lk_va = '0; lk_part = '0; lk_ctx = '0; lk_real = 1'b0;
        ins_va = '0; ins_part = '0; ins_ctx = '0; ins_real = 1'b0; ins_tte = '0;
        cmd_op = '0; cmd_va = '0; cmd_part = '0; cmd_ctx = '0; cmd_real = 1'b0; rd_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 hit after reset", 64'(lk_hit), 64'd0);
        do_lookup("R1 zero key", '0, 3'd0, 13'd0, 1'b0, 1'b0, 2'd0, '0);

        // Fill: empty table takes entries 0..3 in order (R4)
        do_insert(56'h0_1234_6000, 3'd1, 13'd5, 1'b0, mk_tte(64'h00_ABCD_E000, 2'd0, 1'b0));
        do_insert(56'h0_0051_0000, 3'd1, 13'd5, 1'b0, mk_tte(64'h00_7777_0000, 2'd1, 1'b0));
        do_insert(56'h0_0840_0000, 3'd2, 13'd7, 1'b0, mk_tte(64'h01_0040_0000, 2'd2, 1'b1));
        do_insert(56'h0_3000_0000, 3'd1, 13'd0, 1'b1, mk_tte(64'h05_1000_0000, 2'd3, 1'b0));

        for (int k = 0; k < 9; k++) begin
            do_lookup($sformatf("R2 R3 vector %0d", k), VEC[k].va, VEC[k].part, VEC[k].ctx,
                      VEC[k].rl, VEC[k].hit, VEC[k].idx, VEC[k].pa);
        end

        // R11: readback of the 4M locked entry and the 256M real entry
        do_read("R11 entry2", 2'd2, 64'h4100_0000_0840_0007, 64'h01_0040_0042);
        do_read("R11 entry3", 2'd3, 64'h3000_0000_3000_0000, mk_tte(64'h05_1000_0000, 2'd3, 1'b0));

        // R4/R6: used marks now {1,2,3}; insert goes to 0, sweep leaves {0,2}
        do_insert(56'h0_2000_0000, 3'd1, 13'd9, 1'b0, mk_tte(64'h00_2222_2000, 2'd0, 1'b0));
        do_lookup("R4 victim unused 0", 56'h0_2000_0010, 3'd1, 13'd9, 1'b0, 1'b1, 2'd0, 40'h00_2222_2010);
        do_insert(56'h0_2100_0000, 3'd1, 13'd9, 1'b0, mk_tte(64'h00_3333_4000, 2'd0, 1'b0));
        do_lookup("R6 sweep freed entry1", 56'h0_2100_0008, 3'd1, 13'd9, 1'b0, 1'b1, 2'd1, 40'h00_3333_4008);

        // R5: 64K insert over the 8K page in entry 0; victim is unused entry 3
        do_insert(56'h0_2000_0000, 3'd1, 13'd9, 1'b0, mk_tte(64'h00_4444_0000, 2'd1, 1'b0));
        do_lookup("R5 single hit after conflict", 56'h0_2000_1234, 3'd1, 13'd9, 1'b0, 1'b1, 2'd3, 40'h00_4444_1234);
        do_lookup("R4 overwritten entry3 gone", 56'h0_3ABC_DEF0, 3'd1, 13'd0, 1'b1, 1'b0, 2'd0, '0);
        do_read("R5 entry0 removed tag kept", 2'd0, 64'h2300_0000_2000_0009, mk_tte(64'h00_2222_2000, 2'd0, 1'b0));
        do_lookup("R5 neighbour page kept", 56'h0_2100_0008, 3'd1, 13'd9, 1'b0, 1'b1, 2'd1, 40'h00_3333_4008);

        // R7: page demap
        do_cmd(2'd0, 56'h0_2100_0000, 3'd1, 13'd9, 1'b0);
        do_lookup("R7 demapped page", 56'h0_2100_0008, 3'd1, 13'd9, 1'b0, 1'b0, 2'd0, '0);
        do_lookup("R7 other page kept", 56'h0_2000_1234, 3'd1, 13'd9, 1'b0, 1'b1, 2'd3, 40'h00_4444_1234);

        // R8: context demap removes the locked entry
        do_cmd(2'd1, '0, 3'd2, 13'd7, 1'b0);
        do_lookup("R8 locked context entry gone", 56'h0_0840_0010, 3'd2, 13'd7, 1'b0, 1'b0, 2'd0, '0);

        // R9: partition demap spares the locked entry
        do_insert(56'h0_3000_0000, 3'd1, 13'd9, 1'b0, mk_tte(64'h00_5555_6000, 2'd0, 1'b1));
        do_cmd(2'd2, '0, 3'd1, 13'd0, 1'b0);
        do_lookup("R9 locked kept", 56'h0_3000_0100, 3'd1, 13'd9, 1'b0, 1'b1, 2'd0, 40'h00_5555_6100);
        do_lookup("R9 unlocked gone", 56'h0_2000_1234, 3'd1, 13'd9, 1'b0, 1'b0, 2'd0, '0);

        // R12: maintenance and insert together, insert dropped
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_va = 56'h0_7000_0000; cmd_part = 3'd0; cmd_ctx = 13'd0; cmd_real = 1'b0;
        ins_valid = 1'b1; ins_va = 56'h0_6000_0000; ins_part = 3'd1; ins_ctx = 13'd1; ins_real = 1'b0;
        ins_tte = mk_tte(64'h00_6666_6000, 2'd0, 1'b0);
        @(negedge clk);
        cmd_valid = 1'b0; ins_valid = 1'b0;
        do_lookup("R12 insert dropped", 56'h0_6000_0000, 3'd1, 13'd1, 1'b0, 1'b0, 2'd0, '0);

        // R12/R10: lookup beside invalidate-all answers from old state
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd3;
        lk_valid = 1'b1; lk_va = 56'h0_3000_0100; lk_part = 3'd1; lk_ctx = 13'd9; lk_real = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0; lk_valid = 1'b0;
        chk("R12 lookup beside flush hit", 64'(lk_hit), 64'd1);
        chk("R12 lookup beside flush idx", 64'(lk_idx), 64'd0);
        do_lookup("R10 flushed", 56'h0_3000_0100, 3'd1, 13'd9, 1'b0, 1'b0, 2'd0, '0);

        // R10/R4: fill with locked entries 0..3, fifth lands on last
        for (int k = 0; k < 5; k++) begin
            do_insert(56'h0_1000_0000 + 56'(k) * 56'h2000, 3'd3, 13'd2, 1'b0,
                      mk_tte(64'h01_0000_0000 + 64'(k) * 64'h2000, 2'd0, 1'b1));
        end
        do_lookup("R10 refill from entry0", 56'h0_1000_0010, 3'd3, 13'd2, 1'b0, 1'b1, 2'd0, 40'h01_0000_0010);
        do_lookup("R10 refill entry2", 56'h0_1000_4010, 3'd3, 13'd2, 1'b0, 1'b1, 2'd2, 40'h01_0000_4010);
        do_lookup("R4 last entry replaced", 56'h0_1000_6010, 3'd3, 13'd2, 1'b0, 1'b0, 2'd0, '0);
        do_lookup("R4 fallback lands last", 56'h0_1000_8010, 3'd3, 13'd2, 1'b0, 1'b1, 2'd3, 40'h01_0000_8010);
        do_read("R11 fallback entry", 2'd3, 64'h6300_0000_1000_8002, mk_tte(64'h01_0000_8000, 2'd0, 1'b1));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule